// File: doc/BRIEF.md
# I2C Transmit Byte Queue and Serializer

This block is the transmit data path of an I2C controller. Software or a bus agent pushes bytes into a small queue. A shifter takes them one at a time and presents them on SDA, most significant bit first, advancing one bit on each SCL-low strobe. The block does not generate SCL. An external clock engine tells it, through a single-cycle strobe, when each new SCL low phase begins. After the eight data slots comes a ninth slot in which SDA is released so that the addressed receiver can acknowledge. The receiver's answer is sampled on the strobe that closes that slot.

The queue may be empty when the shifter reaches a byte boundary. The block then raises a stretch request, which the clock engine uses to hold SCL low. The request stays up until a byte is written, and that byte is loaded at once. A clear command can abort a transfer. It flushes the queue and overwrites the shift register in the same cycle. If a byte is half sent, its remaining bit slots go out as 1, which leaves SDA released, and the acknowledge slot then follows as normal. A negative acknowledge freezes loading until the next clear. Two interrupt requests support the two ways of feeding the queue. One is a pulse when the queue drains, for loading one byte per interrupt. The other is a level held while occupancy is at or below a low watermark, for keeping the queue topped up.

Top module: `i2c_tx_path`

## Requirements
- R1: The queue holds DEPTH (default 8) bytes and sends them in write order. `fifo_level` gives the occupancy. `fifo_full` is high exactly when the level equals DEPTH, and `fifo_empty` is high exactly when the level is 0.
- R2: A write while `fifo_full` is high leaves the queue contents and level unchanged and sets the sticky `overflow` bit. Only `clear` or reset return `overflow` to 0.
- R3: A loaded byte is driven on `sda_out` MSB first, one bit per `scl_low_strb`. Bit 7 appears in the cycle after the load. The strobe after bit 0 enters the acknowledge slot, where `sda_out` is 1.
- R4: If a strobe reaches a byte boundary (from idle, or at the end of an acknowledged slot with `sda_in`=0) and the queue is empty, `stretch_req` rises. It stays high until a byte is present. That byte is then loaded on the next clock, with no strobe needed, and `stretch_req` falls in the same cycle.
- R5: On `clear` the queue level becomes 0, and from the next cycle `sda_out` is 1. Any remaining bit slots of an interrupted byte are sent as 1 on later strobes, and the acknowledge slot follows after them.
- R6: If `sda_in` is 1 on the strobe that closes the acknowledge slot, `nack_received` becomes 1. No further byte is taken from the queue, the level is held, and `sda_out` stays 1. `clear` returns `nack_received` to 0.
- R7: `irq_empty` is high for exactly one cycle, the first cycle in which the queue has become empty after holding data.
- R8: `irq_level` is high while `fifo_level` is less than or equal to LOW_WM (default 2).
- R9: A write in the same cycle as `clear` is dropped. The level is 0 afterwards and `overflow` is not set.
- R10: After reset, and with no strobe, `sda_out` is 1, `stretch_req` is 0, the queue is empty and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Byte to enqueue |
| clear | input | 1 | Abort: flush the queue and the shifter |
| scl_low_strb | input | 1 | One-cycle pulse at the start of each SCL low phase |
| sda_in | input | 1 | Sampled SDA, read as the acknowledge bit |
| sda_out | output | 1 | SDA drive value (1 = released) |
| stretch_req | output | 1 | Request to hold SCL low |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| fifo_level | output | 4 | Queue occupancy, $clog2(DEPTH+1) bits |
| overflow | output | 1 | Sticky write-while-full flag |
| nack_received | output | 1 | Receiver answered with a NACK |
| irq_empty | output | 1 | One-cycle pulse when the queue drains |
| irq_level | output | 1 | Occupancy at or below the low watermark |

## Verification
The bench sends a byte table bit by bit and checks how the queue drains. It then goes after four corner cases. The first is a clear three bits into a byte. A design that only flushed the queue would keep sending the stale low bits instead of 1s. The second is a starved boundary. Here a wrong design would either never stretch or would wait for a strobe that the stretched clock can never deliver. The third is a NACK while data is still queued. A faulty block would pop the next byte and drive it onto a bus that refused it. The fourth is a write that collides with either a full queue or a clear, which a careless counter would let through or record as an overflow.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_WAIT = 2'd1,
    SH_DATA = 2'd2,
    SH_ACK  = 2'd3
  } sh_state_e;

  // next occupancy after a push and/or a pop in one cycle
  function automatic int unsigned next_level(input int unsigned lvl,
                                             input logic push,
                                             input logic pop);
    if (push && !pop) return lvl + 1;
    if (pop && !push) return lvl - 1;
    return lvl;
  endfunction

  // advance the shifter by one bit, refilling from the bottom with 1s
  function automatic logic [BYTE_W-1:0] shift_fill_one(input logic [BYTE_W-1:0] s);
    return {s[BYTE_W-2:0], 1'b1};
  endfunction

  // queue pointer increment with wrap at an arbitrary depth
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/i2c_tx_fifo.sv
module i2c_tx_fifo
  import i2c_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push_req,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic              full,
  output logic              empty,
  output logic [LW-1:0]     level,
  output logic              overflow
);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic ovf_q;
  logic push_ok, pop_ok;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push_req && !clear && !full;
  assign pop_ok  = pop && !clear && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else if (clear) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_ok) wp <= AW'(ptr_next(32'(wp), DEPTH));
      if (pop_ok)  rp <= AW'(ptr_next(32'(rp), DEPTH));
      cnt <= LW'(next_level(32'(cnt), push_ok, pop_ok));
      if (push_req && full) ovf_q <= 1'b1;
    end
  end

  assign head     = mem[rp];
  assign level    = cnt;
  assign overflow = ovf_q;

endmodule

// File: rtl/i2c_tx_shifter.sv
module i2c_tx_shifter
  import i2c_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              clear,
  input  logic              sda_in,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] head,
  output logic              pop,
  output logic              at_boundary,
  output logic              sda_out,
  output logic              stretch_req,
  output logic              nack
);

  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

  sh_state_e         state;
  logic [BYTE_W-1:0] shreg;
  logic [BW-1:0]     bidx;
  logic              nack_q;
  logic              can_load;
  logic              nack_seen;

  assign nack_seen   = (state == SH_ACK) && strobe && sda_in;
  assign at_boundary = (state == SH_WAIT)
                     || ((state == SH_IDLE) && strobe)
                     || ((state == SH_ACK) && strobe && !sda_in);
  assign can_load    = !fifo_empty && !clear && !nack_q;
  assign pop         = at_boundary && can_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SH_IDLE;
      shreg  <= '1;
      bidx   <= '0;
      nack_q <= 1'b0;
    end else begin
      if (clear) nack_q <= 1'b0;
      case (state)
        SH_DATA: begin
          if (clear) shreg <= '1;
          else if (strobe && bidx != LAST_BIT) shreg <= shift_fill_one(shreg);
          if (strobe) begin
            if (bidx == LAST_BIT) state <= SH_ACK;
            else bidx <= bidx + BW'(1);
          end
        end
        default: begin
          if (nack_seen) begin
            if (!clear) nack_q <= 1'b1;
            state <= SH_IDLE;
          end else if (at_boundary) begin
            if (pop) begin
              shreg <= head;
              bidx  <= '0;
              state <= SH_DATA;
            end else if (nack_q && !clear) begin
              state <= SH_IDLE;
            end else begin
              state <= SH_WAIT;
            end
          end
        end
      endcase
    end
  end

  assign sda_out     = (state == SH_DATA) ? shreg[BYTE_W-1] : 1'b1;
  assign stretch_req = (state == SH_WAIT);
  assign nack        = nack_q;

endmodule

// File: rtl/i2c_tx_irq.sv
module i2c_tx_irq #(
  parameter int DEPTH  = 8,
  parameter int LOW_WM = 2,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_empty,
  input  logic [LW-1:0] level,
  output logic          irq_empty,
  output logic          irq_level
);

  logic empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b1;
    else        empty_q <= fifo_empty;
  end

  assign irq_empty = fifo_empty && !empty_q;
  assign irq_level = (level <= LW'(LOW_WM));

endmodule

// File: rtl/i2c_tx_path.sv
module i2c_tx_path
  import i2c_tx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LOW_WM = 2,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              clear,
  input  logic              scl_low_strb,
  input  logic              sda_in,
  output logic              sda_out,
  output logic              stretch_req,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic [LW-1:0]     fifo_level,
  output logic              overflow,
  output logic              nack_received,
  output logic              irq_empty,
  output logic              irq_level
);

  logic [BYTE_W-1:0] head;
  logic load_evt;
  logic at_boundary;

  i2c_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .push_req (wr_valid),
    .push_data(wr_data),
    .pop      (load_evt),
    .head     (head),
    .full     (fifo_full),
    .empty    (fifo_empty),
    .level    (fifo_level),
    .overflow (overflow)
  );

  i2c_tx_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (scl_low_strb),
    .clear      (clear),
    .sda_in     (sda_in),
    .fifo_empty (fifo_empty),
    .head       (head),
    .pop        (load_evt),
    .at_boundary(at_boundary),
    .sda_out    (sda_out),
    .stretch_req(stretch_req),
    .nack       (nack_received)
  );

  i2c_tx_irq #(.DEPTH(DEPTH), .LOW_WM(LOW_WM)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_empty(fifo_empty),
    .level     (fifo_level),
    .irq_empty (irq_empty),
    .irq_level (irq_level)
  );

endmodule

// File: rtl/i2c_tx_path_chk.sv
module i2c_tx_path_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          wr_valid,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic [LW-1:0] fifo_level,
  input logic          overflow,
  input logic          sda_out,
  input logic          stretch_req,
  input logic          nack_received,
  input logic          load_evt,
  input logic          at_boundary
);

  a_r1_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  a_r2_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && fifo_full && !clear |=> overflow);

  a_r2_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clear |=> overflow);

  a_r4_load_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !fifo_empty && at_boundary);

  a_r4_stretch_release: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_req && !fifo_empty && !clear |=> !stretch_req);

  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> fifo_empty && fifo_level == '0);

  a_r5_clear_pads: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> sda_out);

  a_r6_nack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    nack_received && !clear |=> nack_received);

  a_r6_no_load_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    nack_received |-> !load_evt);

  a_r9_clear_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
    clear && wr_valid |=> !overflow && fifo_level == '0);

endmodule

bind i2c_tx_path i2c_tx_path_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clear        (clear),
  .wr_valid     (wr_valid),
  .fifo_full    (fifo_full),
  .fifo_empty   (fifo_empty),
  .fifo_level   (fifo_level),
  .overflow     (overflow),
  .sda_out      (sda_out),
  .stretch_req  (stretch_req),
  .nack_received(nack_received),
  .load_evt     (load_evt),
  .at_boundary  (at_boundary)
);

// File: tb/i2c_tx_path_bench.sv
module i2c_tx_path_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int LOW_WM = 2;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int NVEC = 4;
  localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h3C, 8'h81, 8'h6E};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic clear = 1'b0;
  logic scl_low_strb = 1'b0;
  logic sda_in = 1'b0;
  logic sda_out, stretch_req, fifo_full, fifo_empty, overflow;
  logic nack_received, irq_empty, irq_level;
  logic [LW-1:0] fifo_level;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_tx_path #(.DEPTH(DEPTH), .LOW_WM(LOW_WM)) u_i2c_tx_path (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .clear(clear), .scl_low_strb(scl_low_strb), .sda_in(sda_in),
    .sda_out(sda_out), .stretch_req(stretch_req), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .fifo_level(fifo_level), .overflow(overflow),
    .nack_received(nack_received), .irq_empty(irq_empty), .irq_level(irq_level)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic ack);
    @(negedge clk);
    scl_low_strb = 1'b1;
    sda_in = ack;
    @(posedge clk);
    @(negedge clk);
    scl_low_strb = 1'b0;
    sda_in = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_clear(input logic with_write);
    @(negedge clk);
    clear = 1'b1;
    wr_valid = with_write;
    wr_data = 8'hDD;
    @(posedge clk);
    @(negedge clk);
    clear = 1'b0;
    wr_valid = 1'b0;
  endtask

  function automatic logic bit_of(input logic [7:0] b, input int k);
    return b[7 - k];
  endfunction

  // shift out bits 1..7 of a byte already loaded, then enter the ack slot
  task automatic send_rest(input logic [7:0] b, input string tag);
    for (int k = 1; k < 8; k++) begin
      strobe(1'b0);
      chk(tag, sda_out, bit_of(b, k));
    end
    strobe(1'b0);
    chk("R3 ack slot released", sda_out, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R10 reset / idle state
    chk("R10 sda idle", sda_out, 1'b1);
    chk("R10 no stretch", stretch_req, 1'b0);
    chk("R10 empty", fifo_empty, 1'b1);
    chk("R10 level", fifo_level, 0);
    chk("R10 overflow", overflow, 1'b0);
    chk("R10 nack", nack_received, 1'b0);
    chk("R10 irq_empty", irq_empty, 1'b0);

    // table-driven: enqueue all, then serialize in order
    for (int i = 0; i < NVEC; i++) wr(VEC[i]);
    chk("R1 level after writes", fifo_level, NVEC);
    chk("R8 irq_level above watermark", irq_level, 1'b0);
    for (int i = 0; i < NVEC; i++) begin
      strobe(1'b0);
      chk("R3 msb first", sda_out, bit_of(VEC[i], 0));
      chk("R1 level after load", fifo_level, NVEC - 1 - i);
      chk("R8 irq_level", irq_level, (NVEC - 1 - i) <= LOW_WM);
      chk("R7 irq_empty on drain", irq_empty, i == NVEC - 1);
      if (i == NVEC - 1) begin
        tick();
        chk("R7 irq_empty single cycle", irq_empty, 1'b0);
      end
      send_rest(VEC[i], "R3 serial bit");
    end

    // R4 starved boundary then late data
    strobe(1'b0);
    chk("R4 stretch at empty boundary", stretch_req, 1'b1);
    tick();
    chk("R4 stretch held", stretch_req, 1'b1);
    wr(8'h5A);
    chk("R4 stretch until load", stretch_req, 1'b1);
    tick();
    chk("R4 stretch released", stretch_req, 1'b0);
    chk("R4 loaded msb", sda_out, bit_of(8'h5A, 0));
    send_rest(8'h5A, "R4 late byte bit");

    // R1/R2 fill to full and overflow
    for (int k = 0; k < DEPTH; k++) wr(8'h90 + 8'(k));
    chk("R1 full", fifo_full, 1'b1);
    chk("R1 level full", fifo_level, DEPTH);
    wr(8'hEE);
    chk("R2 overflow set", overflow, 1'b1);
    chk("R2 level unchanged", fifo_level, DEPTH);
    strobe(1'b0);
    chk("R1 first-in first-out", sda_out, bit_of(8'h90, 0));
    strobe(1'b0);
    chk("R1 bit6", sda_out, bit_of(8'h90, 1));
    tick();
    chk("R2 overflow sticky", overflow, 1'b1);
    strobe(1'b0);
    chk("R1 bit5", sda_out, bit_of(8'h90, 2));

    // R5 mid-byte clear
    do_clear(1'b0);
    chk("R5 level zero", fifo_level, 0);
    chk("R5 empty", fifo_empty, 1'b1);
    chk("R2 overflow cleared", overflow, 1'b0);
    chk("R5 sda padded now", sda_out, 1'b1);
    for (int k = 3; k < 8; k++) begin
      strobe(1'b0);
      chk("R5 padded bit", sda_out, 1'b1);
    end
    strobe(1'b0);
    chk("R5 ack slot after pad", sda_out, 1'b1);
    chk("R5 no stretch in ack slot", stretch_req, 1'b0);
    strobe(1'b0);
    chk("R4 stretch after abort", stretch_req, 1'b1);

    // R9 clear collides with write
    do_clear(1'b1);
    chk("R9 write dropped", fifo_level, 0);
    chk("R9 no overflow", overflow, 1'b0);

    // R6 NACK with data pending
    wr(8'hC3);
    tick();
    chk("R6 byte loaded from wait", sda_out, bit_of(8'hC3, 0));
    wr(8'h77);
    chk("R6 pending level", fifo_level, 1);
    send_rest(8'hC3, "R6 byte bit");
    strobe(1'b1);
    chk("R6 nack flag", nack_received, 1'b1);
    chk("R6 sda released", sda_out, 1'b1);
    chk("R6 level held", fifo_level, 1);
    chk("R6 no stretch", stretch_req, 1'b0);
    strobe(1'b0);
    strobe(1'b0);
    chk("R6 still no load", fifo_level, 1);
    chk("R6 sda still released", sda_out, 1'b1);
    do_clear(1'b0);
    chk("R6 nack cleared", nack_received, 1'b0);
    chk("R5 level after clear", fifo_level, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule